// File: doc/BRIEF.md
# Strictly Ordered Single-Port Bus Sequencer

This block lets three clients share one bus initiator port: an instruction cache that needs a word on a miss, a data cache that needs a word on a miss or an uncached read, and a posted write buffer that drains stores as bursts. It sends one transaction at a time. A transaction is a single read command beat, or a write burst of one or more beats that ends with a beat marked last. After the last command beat is accepted, no further command is sent until the response carrying the same transaction identifier has returned. This keeps memory accesses in processor program order even when the interconnect may return responses out of order.

The selection rule follows program order. Writes in the buffer are older than any read the processor is stalled on, so they drain first. A pending data read belongs to an older instruction than a pending instruction fetch, so it beats the fetch. A requester holds its request until its done pulse and lowers it in that same cycle. The write buffer is assumed not to take new entries while a read is pending; the processor is stalled then.

Responses go back to the client that issued the transaction. Read data and the error flag appear on that side's outputs together with a one-cycle done pulse. An error on a write burst raises a separate write-error pulse. A response that arrives with nothing outstanding, or with the wrong identifier, is dropped and raises a protocol-error pulse.

Top module: `ordered_bus_seq`

## Requirements
- R1: During and straight after reset, cmd_valid, every done pulse, ins_err, dat_err, wr_err and proto_err are low, and the first transaction carries identifier 0.
- R2: After a command beat with cmd_last high is accepted, cmd_valid stays low until a response with the matching identifier has been taken.
- R3: While wb_valid is high, no read command (cmd_write low) is presented. When writes and reads are pending together, the whole write burst is sent first.
- R4: When a data read and an instruction read are both pending at selection time, the data read is sent first.
- R5: A read transaction is one beat with cmd_write low, cmd_last high and cmd_addr equal to the requester's address. The response data appears on that side's rdata with a one-cycle done pulse in the cycle after the response is taken.
- R6: A write burst forwards the buffer's head entries in order as beats (address, data, last flag copied). wb_pop is high for exactly the accepted beats, and the burst gets a single response.
- R7: Identifiers start at 0 and advance by one (mod 2^TID_W) per transaction. Every beat of a burst carries the same identifier.
- R8: A response whose identifier does not match the outstanding transaction, or that arrives with no transaction outstanding, is ignored, and proto_err pulses in the following cycle.
- R9: A response error on a read is reported on the issuing side's err output together with its done pulse. On a write burst it raises a one-cycle wr_err pulse with no done pulse.
- R10: While cmd_valid is high and cmd_ready is low, the command beat (valid, address, write flag, identifier) holds steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ins_req | input | 1 | Instruction-side read pending, held until ins_done |
| ins_addr | input | AW | Instruction read address |
| ins_done | output | 1 | Instruction read completed (pulse) |
| ins_rdata | output | DW | Instruction read data |
| ins_err | output | 1 | Instruction read bus error, valid with ins_done |
| dat_req | input | 1 | Data-side read pending, held until dat_done |
| dat_addr | input | AW | Data read address |
| dat_done | output | 1 | Data read completed (pulse) |
| dat_rdata | output | DW | Data read data |
| dat_err | output | 1 | Data read bus error, valid with dat_done |
| wb_valid | input | 1 | Write buffer head entry present |
| wb_addr | input | AW | Head entry address |
| wb_data | input | DW | Head entry data |
| wb_last | input | 1 | Head entry ends its burst |
| wb_pop | output | 1 | Head entry consumed this cycle |
| wr_err | output | 1 | Write burst bus error (pulse) |
| cmd_valid | output | 1 | Command beat valid |
| cmd_ready | input | 1 | Bus accepts the command beat |
| cmd_write | output | 1 | Beat is a write |
| cmd_addr | output | AW | Beat address |
| cmd_wdata | output | DW | Beat write data |
| cmd_last | output | 1 | Last beat of the transaction |
| cmd_tid | output | TID_W | Transaction identifier |
| rsp_valid | input | 1 | Response present (always accepted) |
| rsp_tid | input | TID_W | Response identifier |
| rsp_data | input | DW | Response read data |
| rsp_err | input | 1 | Response bus error |
| proto_err | output | 1 | Unexpected or mismatched response (pulse) |

## Verification
The embedded properties watch on every cycle that nothing is sent after a last beat while a response is owed, that no read is presented while the write buffer holds entries, that a data read is chosen over a simultaneous fetch, that a stalled beat holds, and that the error and done outputs stay consistent. Only the bench scenarios can show the full transaction order against the program order it built, the identifier sequence, the routed data values, and that stray or mismatched responses are dropped while the real response still completes correctly. These are checked by logging every accepted beat under random bus back-pressure and random response delay.

// File: rtl/obs_pkg.sv
// Shared types for the ordered bus sequencer.
// Assumes: two-bit encodings are enough for the source and state sets.
package obs_pkg;
    typedef enum logic [1:0] {
        SRC_WR   = 2'd0,
        SRC_DAT  = 2'd1,
        SRC_INS  = 2'd2,
        SRC_NONE = 2'd3
    } src_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CMD  = 2'd1,
        ST_WAIT = 2'd2
    } st_e;
endpackage

// File: rtl/obs_select.sv
// Source selection in program order: buffered writes, then data read,
// then instruction fetch.
// Assumes: the buffer only fills while no read is pending.
module obs_select
    import obs_pkg::*;
(
    input  logic wb_valid,
    input  logic dat_req,
    input  logic ins_req,
    output src_e pick
);
    // Fixed priority mirrors the age of each pending access.
    always_comb begin
        if (wb_valid)     pick = SRC_WR;
        else if (dat_req) pick = SRC_DAT;
        else if (ins_req) pick = SRC_INS;
        else              pick = SRC_NONE;
    end
endmodule

// File: rtl/obs_issue.sv
// Command issue: latches the chosen source, drives command beats, and
// holds the single transaction window until the response is taken.
// Assumes: requesters hold address and request until their done pulse.
module obs_issue
    import obs_pkg::*;
#(
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int TID_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  src_e             pick,
    input  logic [AW-1:0]    ins_addr,
    input  logic [AW-1:0]    dat_addr,
    input  logic             wb_valid,
    input  logic [AW-1:0]    wb_addr,
    input  logic [DW-1:0]    wb_data,
    input  logic             wb_last,
    input  logic             cmd_ready,
    input  logic             rsp_take,
    output logic             cmd_valid,
    output logic             cmd_write,
    output logic [AW-1:0]    cmd_addr,
    output logic [DW-1:0]    cmd_wdata,
    output logic             cmd_last,
    output logic [TID_W-1:0] cmd_tid,
    output logic             wb_pop,
    output st_e              state,
    output src_e             cur_src
);
    localparam logic [TID_W-1:0] TID_ONE = {{(TID_W-1){1'b0}}, 1'b1};

    logic [AW-1:0]    rd_addr_q;
    logic [TID_W-1:0] tid_q;
    logic             is_wr;
    logic             beat_fire;

    assign is_wr     = (cur_src == SRC_WR);
    assign cmd_valid = (state == ST_CMD) && (is_wr ? wb_valid : 1'b1);
    assign cmd_write = is_wr;
    assign cmd_addr  = is_wr ? wb_addr : rd_addr_q;
    assign cmd_wdata = is_wr ? wb_data : '0;
    assign cmd_last  = is_wr ? wb_last : 1'b1;
    assign cmd_tid   = tid_q;
    assign beat_fire = cmd_valid && cmd_ready;
    assign wb_pop    = beat_fire && is_wr;

    // Sequencer state, latched source and read address, identifier count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            cur_src   <= SRC_NONE;
            rd_addr_q <= '0;
            tid_q     <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (pick != SRC_NONE) begin
                        cur_src   <= pick;
                        rd_addr_q <= (pick == SRC_DAT) ? dat_addr : ins_addr;
                        state     <= ST_CMD;
                    end
                end
                ST_CMD: begin
                    if (beat_fire && cmd_last) state <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (rsp_take) begin
                        state <= ST_IDLE;
                        tid_q <= tid_q + TID_ONE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    AST_NO_CMD_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && cmd_last) |=> !cmd_valid); // R2
    AST_CMD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_addr)
            && $stable(cmd_tid) && $stable(cmd_write))); // R10
    AST_READ_AFTER_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_write) |-> !wb_valid); // R3
endmodule

// File: rtl/obs_route.sv
// Response matching and routing: accepts only the response for the
// outstanding identifier and returns data or errors to its requester.
// Assumes: responses are always accepted (no back-pressure).
module obs_route
    import obs_pkg::*;
#(
    parameter int DW    = 32,
    parameter int TID_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  st_e              state,
    input  src_e             cur_src,
    input  logic [TID_W-1:0] cur_tid,
    input  logic             rsp_valid,
    input  logic [TID_W-1:0] rsp_tid,
    input  logic [DW-1:0]    rsp_data,
    input  logic             rsp_err,
    output logic             rsp_take,
    output logic             ins_done,
    output logic [DW-1:0]    ins_rdata,
    output logic             ins_err,
    output logic             dat_done,
    output logic [DW-1:0]    dat_rdata,
    output logic             dat_err,
    output logic             wr_err,
    output logic             proto_err
);
    assign rsp_take = rsp_valid && (state == ST_WAIT) && (rsp_tid == cur_tid);

    // Registered pulses and data toward the requesting side.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ins_done  <= 1'b0;
            ins_err   <= 1'b0;
            ins_rdata <= '0;
            dat_done  <= 1'b0;
            dat_err   <= 1'b0;
            dat_rdata <= '0;
            wr_err    <= 1'b0;
            proto_err <= 1'b0;
        end else begin
            ins_done  <= rsp_take && (cur_src == SRC_INS);
            ins_err   <= rsp_take && (cur_src == SRC_INS) && rsp_err;
            dat_done  <= rsp_take && (cur_src == SRC_DAT);
            dat_err   <= rsp_take && (cur_src == SRC_DAT) && rsp_err;
            wr_err    <= rsp_take && (cur_src == SRC_WR) && rsp_err;
            proto_err <= rsp_valid && !rsp_take;
            if (rsp_take && cur_src == SRC_INS) ins_rdata <= rsp_data;
            if (rsp_take && cur_src == SRC_DAT) dat_rdata <= rsp_data;
        end
    end

    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ins_done, dat_done, wr_err, proto_err})); // R8
    AST_PROTO_NEEDS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |-> $past(rsp_valid)); // R8
    AST_INS_ERR_PAIRED: assert property (@(posedge clk) disable iff (!rst_n)
        ins_err |-> ins_done); // R9
    AST_DAT_ERR_PAIRED: assert property (@(posedge clk) disable iff (!rst_n)
        dat_err |-> dat_done); // R9
endmodule

// File: rtl/ordered_bus_seq.sv
// Top: shares one bus initiator port between instruction reads, data
// reads and posted write bursts, one transaction at a time, in program order.
// Assumes: requesters hold requests until done; the write buffer does not
// fill while a read is pending.
module ordered_bus_seq
    import obs_pkg::*;
#(
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int TID_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ins_req,
    input  logic [AW-1:0]    ins_addr,
    output logic             ins_done,
    output logic [DW-1:0]    ins_rdata,
    output logic             ins_err,
    input  logic             dat_req,
    input  logic [AW-1:0]    dat_addr,
    output logic             dat_done,
    output logic [DW-1:0]    dat_rdata,
    output logic             dat_err,
    input  logic             wb_valid,
    input  logic [AW-1:0]    wb_addr,
    input  logic [DW-1:0]    wb_data,
    input  logic             wb_last,
    output logic             wb_pop,
    output logic             wr_err,
    output logic             cmd_valid,
    input  logic             cmd_ready,
    output logic             cmd_write,
    output logic [AW-1:0]    cmd_addr,
    output logic [DW-1:0]    cmd_wdata,
    output logic             cmd_last,
    output logic [TID_W-1:0] cmd_tid,
    input  logic             rsp_valid,
    input  logic [TID_W-1:0] rsp_tid,
    input  logic [DW-1:0]    rsp_data,
    input  logic             rsp_err,
    output logic             proto_err
);
    src_e pick;
    src_e cur_src;
    st_e  state;
    logic rsp_take;

    obs_select u_select (
        .wb_valid (wb_valid),
        .dat_req  (dat_req),
        .ins_req  (ins_req),
        .pick     (pick)
    );

    obs_issue #(.AW(AW), .DW(DW), .TID_W(TID_W)) u_issue (
        .clk       (clk),
        .rst_n     (rst_n),
        .pick      (pick),
        .ins_addr  (ins_addr),
        .dat_addr  (dat_addr),
        .wb_valid  (wb_valid),
        .wb_addr   (wb_addr),
        .wb_data   (wb_data),
        .wb_last   (wb_last),
        .cmd_ready (cmd_ready),
        .rsp_take  (rsp_take),
        .cmd_valid (cmd_valid),
        .cmd_write (cmd_write),
        .cmd_addr  (cmd_addr),
        .cmd_wdata (cmd_wdata),
        .cmd_last  (cmd_last),
        .cmd_tid   (cmd_tid),
        .wb_pop    (wb_pop),
        .state     (state),
        .cur_src   (cur_src)
    );

    obs_route #(.DW(DW), .TID_W(TID_W)) u_route (
        .clk       (clk),
        .rst_n     (rst_n),
        .state     (state),
        .cur_src   (cur_src),
        .cur_tid   (cmd_tid),
        .rsp_valid (rsp_valid),
        .rsp_tid   (rsp_tid),
        .rsp_data  (rsp_data),
        .rsp_err   (rsp_err),
        .rsp_take  (rsp_take),
        .ins_done  (ins_done),
        .ins_rdata (ins_rdata),
        .ins_err   (ins_err),
        .dat_done  (dat_done),
        .dat_rdata (dat_rdata),
        .dat_err   (dat_err),
        .wr_err    (wr_err),
        .proto_err (proto_err)
    );

    AST_DATA_BEFORE_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_write && dat_req && ins_req) |-> (cmd_addr == dat_addr)); // R4
endmodule

// File: tb/ordered_bus_seq_tb.sv
module ordered_bus_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 32;
    localparam int DW = 32;
    localparam int TID_W = 4;
    localparam int LOGN = 2048;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ins_req = 1'b0, dat_req = 1'b0;
    logic [AW-1:0] ins_addr = '0, dat_addr = '0;
    logic ins_done, ins_err, dat_done, dat_err, wb_pop, wr_err, proto_err;
    logic [DW-1:0] ins_rdata, dat_rdata;
    logic wb_valid, wb_last;
    logic [AW-1:0] wb_addr;
    logic [DW-1:0] wb_data;
    logic cmd_valid, cmd_write, cmd_last;
    logic cmd_ready;
    logic [AW-1:0] cmd_addr;
    logic [DW-1:0] cmd_wdata;
    logic [TID_W-1:0] cmd_tid;
    logic rsp_valid, rsp_err;
    logic [TID_W-1:0] rsp_tid;
    logic [DW-1:0] rsp_data;

    always #(CLK_PERIOD/2) clk = ~clk;

    ordered_bus_seq #(.AW(AW), .DW(DW), .TID_W(TID_W)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .ins_req(ins_req), .ins_addr(ins_addr), .ins_done(ins_done),
        .ins_rdata(ins_rdata), .ins_err(ins_err),
        .dat_req(dat_req), .dat_addr(dat_addr), .dat_done(dat_done),
        .dat_rdata(dat_rdata), .dat_err(dat_err),
        .wb_valid(wb_valid), .wb_addr(wb_addr), .wb_data(wb_data),
        .wb_last(wb_last), .wb_pop(wb_pop), .wr_err(wr_err),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_write(cmd_write),
        .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .cmd_last(cmd_last),
        .cmd_tid(cmd_tid), .rsp_valid(rsp_valid), .rsp_tid(rsp_tid),
        .rsp_data(rsp_data), .rsp_err(rsp_err), .proto_err(proto_err)
    );

    int n_chk = 0, n_bad = 0;

    // Reference rules for the bus model: data and error per address.
    function automatic logic [DW-1:0] data_of(input logic [AW-1:0] a);
        return {a[15:0], ~a[15:0]} ^ 32'h5A5A_0000;
    endfunction
    function automatic logic err_of(input logic [AW-1:0] a);
        return a[7:0] == 8'hEC;
    endfunction

    task automatic chk(input bit ok, input string r, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", r, act, exp);
        end
    endtask

    // Write buffer model
    logic [AW-1:0] wb_a [64];
    logic [DW-1:0] wb_d [64];
    logic          wb_l [64];
    int wb_head = 0, wb_tail = 0;
    assign wb_valid = (wb_head != wb_tail);
    assign wb_addr  = wb_a[wb_head % 64];
    assign wb_data  = wb_d[wb_head % 64];
    assign wb_last  = wb_l[wb_head % 64];

    // Expected beat list
    logic          exp_w [LOGN];
    logic [AW-1:0] exp_a [LOGN];
    logic [DW-1:0] exp_d [LOGN];
    logic          exp_l [LOGN];
    int            exp_t [LOGN];
    int exp_n = 0, n_txn = 0, exp_wr_err = 0, exp_proto = 0;

    // Logged beats from the bus
    logic          log_w [LOGN];
    logic [AW-1:0] log_a [LOGN];
    logic [DW-1:0] log_d [LOGN];
    logic          log_l [LOGN];
    logic [TID_W-1:0] log_t [LOGN];
    int log_n = 0;

    // Bus slave state
    bit bogus_mode = 0;
    int inj_cnt = 0, inj_done = 0;
    logic pend = 0, in_burst = 0;
    logic [TID_W-1:0] pend_tid;
    logic [AW-1:0] pend_a, burst_a;
    int dly = 0;
    int wr_err_cnt = 0, proto_cnt = 0;

    // Reactive bus slave: random ready, logs beats, returns delayed responses.
    always @(posedge clk) begin
        if (!rst_n) begin
            cmd_ready <= 1'b0; rsp_valid <= 1'b0; rsp_tid <= '0;
            rsp_data <= '0; rsp_err <= 1'b0; pend <= 1'b0; in_burst <= 1'b0;
        end else begin
            cmd_ready <= ($urandom_range(3) != 0);
            rsp_valid <= 1'b0;
            if (wb_pop) wb_head <= wb_head + 1;
            if (wr_err) wr_err_cnt <= wr_err_cnt + 1;
            if (proto_err) proto_cnt <= proto_cnt + 1;
            if (cmd_valid && cmd_ready) begin
                log_w[log_n] <= cmd_write; log_a[log_n] <= cmd_addr;
                log_d[log_n] <= cmd_wdata; log_l[log_n] <= cmd_last;
                log_t[log_n] <= cmd_tid;   log_n <= log_n + 1;
                if (!in_burst) burst_a <= cmd_addr;
                in_burst <= !cmd_last;
                if (cmd_last) begin
                    pend <= 1'b1; pend_tid <= cmd_tid;
                    pend_a <= in_burst ? burst_a : cmd_addr;
                    dly <= bogus_mode ? 3 : int'($urandom_range(2));
                end
            end else if (pend) begin
                if (dly == 0) begin
                    rsp_valid <= 1'b1; rsp_tid <= pend_tid;
                    rsp_data <= data_of(pend_a); rsp_err <= err_of(pend_a);
                    pend <= 1'b0;
                end else begin
                    if (bogus_mode && dly == 2) begin
                        rsp_valid <= 1'b1; rsp_tid <= pend_tid + 1'b1;
                        rsp_data <= 32'hDEAD_BEEF; rsp_err <= 1'b1;
                    end
                    dly <= dly - 1;
                end
            end else if (inj_done != inj_cnt) begin
                rsp_valid <= 1'b1; rsp_tid <= TID_W'(inj_done);
                rsp_data <= 32'h0BAD_0BAD; rsp_err <= 1'b0;
                inj_done <= inj_done + 1;
            end
        end
    end

    task automatic add_beat(input logic w, input logic [AW-1:0] a, input logic [DW-1:0] d, input logic l);
        exp_w[exp_n] = w; exp_a[exp_n] = a; exp_d[exp_n] = d;
        exp_l[exp_n] = l; exp_t[exp_n] = n_txn; exp_n++;
    endtask

    task automatic push_burst(input logic [AW-1:0] base, input int len);
        for (int i = 0; i < len; i++) begin
            logic [DW-1:0] d;
            d = $urandom;
            wb_a[wb_tail % 64] = base + AW'(4 * i);
            wb_d[wb_tail % 64] = d;
            wb_l[wb_tail % 64] = (i == len - 1);
            wb_tail++;
            add_beat(1'b1, base + AW'(4 * i), d, i == len - 1);
        end
        if (err_of(base)) exp_wr_err++;
        n_txn++;
    endtask

    function automatic logic [AW-1:0] rand_addr();
        logic [AW-1:0] a;
        a = $urandom;
        a[1:0] = 2'b00;
        if ($urandom_range(5) == 0) a[7:0] = 8'hEC;
        return a;
    endfunction

    // One round: bursts first, then the reads, all raised in one cycle.
    task automatic do_round(input int nb, input int blen, input bit dd, input bit di,
                            input logic [AW-1:0] ad, input logic [AW-1:0] ai, input bit bog);
        int t;
        @(negedge clk);
        bogus_mode = bog;
        for (int b = 0; b < nb; b++) push_burst(rand_addr(), blen);
        if (dd) begin add_beat(1'b0, ad, '0, 1'b1); n_txn++; end
        if (di) begin add_beat(1'b0, ai, '0, 1'b1); n_txn++; end
        if (bog) exp_proto += nb + int'(dd) + int'(di);
        dat_addr = ad; dat_req = dd; ins_addr = ai; ins_req = di;
        t = 0;
        while ((dat_req || ins_req) && t < 400) begin
            @(negedge clk);
            t++;
            if (dat_done) begin
                chk(dat_rdata == data_of(ad), "R5 dat_rdata", dat_rdata, data_of(ad));
                chk(dat_err == err_of(ad), "R9 dat_err", 32'(dat_err), 32'(err_of(ad)));
                dat_req = 1'b0;
            end
            if (ins_done) begin
                chk(ins_rdata == data_of(ai), "R5 ins_rdata", ins_rdata, data_of(ai));
                chk(ins_err == err_of(ai), "R9 ins_err", 32'(ins_err), 32'(err_of(ai)));
                ins_req = 1'b0;
            end
        end
        chk(t < 400, "R5 read completion", 32'(t), 32'd400);
        t = 0;
        while ((wb_head != wb_tail || pend) && t < 400) begin @(negedge clk); t++; end
        repeat (4) @(negedge clk);
        chk(t < 400, "R6 buffer drain", 32'(t), 32'd400);
        bogus_mode = 0;
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        // R1: outputs quiet during reset
        chk(!cmd_valid && !ins_done && !dat_done && !wr_err && !proto_err && !ins_err && !dat_err,
            "R1 reset outputs", {cmd_valid, ins_done, dat_done, wr_err, proto_err}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!cmd_valid && !proto_err, "R1 after reset", {cmd_valid, proto_err}, 0);

        // Directed corners
        do_round(0, 0, 0, 1, '0, 32'h0000_1000, 0);             // R5 fetch alone
        do_round(0, 0, 1, 0, 32'h0000_20EC, '0, 0);             // R9 data error
        do_round(2, 3, 1, 1, 32'h0000_3000, 32'h0000_4000, 0);  // R3 R4 R6
        @(negedge clk);
        push_burst(32'h0000_50EC, 2);                           // R9 write error
        do_round(0, 0, 0, 0, '0, '0, 0);
        inj_cnt++; exp_proto++;                                 // R8 stray while idle
        repeat (6) @(negedge clk);
        do_round(0, 0, 1, 1, 32'h0000_6000, 32'h0000_7000, 1);  // R8 mismatched tid
        do_round(1, 4, 0, 1, '0, 32'h0000_80EC, 1);

        // Random rounds
        for (int r = 0; r < 80; r++) begin
            do_round(int'($urandom_range(2)), 1 + int'($urandom_range(3)),
                     bit'($urandom_range(1)), bit'($urandom_range(1)),
                     rand_addr(), rand_addr(), ($urandom_range(7) == 0));
        end
        repeat (10) @(negedge clk);

        // Order, content and identifiers of every beat
        chk(log_n == exp_n, "R2 beat count", 32'(log_n), 32'(exp_n));
        for (int i = 0; i < exp_n && i < log_n; i++) begin
            chk(log_w[i] == exp_w[i] && log_a[i] == exp_a[i], "R3 R4 beat order",
                log_a[i], exp_a[i]);
            chk(log_l[i] == exp_l[i] && (!exp_w[i] || log_d[i] == exp_d[i]),
                "R6 beat content", log_d[i], exp_d[i]);
            chk(log_t[i] == TID_W'(exp_t[i]), "R7 tid", 32'(log_t[i]), 32'(TID_W'(exp_t[i])));
        end
        chk(wr_err_cnt == exp_wr_err, "R9 wr_err count", 32'(wr_err_cnt), 32'(exp_wr_err));
        chk(proto_cnt == exp_proto, "R8 proto_err count", 32'(proto_cnt), 32'(exp_proto));
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule